// File: doc/BRIEF.md
# Dual-Output Masked Interrupt Controller

This block gathers 32 level-sensitive request lines into one raw level vector. It drives two separate processor interrupt outputs from that vector: a normal request and a fast request. Each output has its own enable mask. An output is asserted while any raw line that its mask enables is high. Neither output does prioritising, vectoring or edge capture.

Software controls the masks through a word-indexed register port. The set and clear actions use separate register indices, so a mask bit can be changed without a read-modify-write. Both the raw vector and the masked status can be read back for each output. Line 0 also carries a software request. Software sets and clears a latch that is ORed with external line 0.

Top module: `dual_mask_intc`

## Requirements
- R1: `irq_o` is high exactly when (raw level AND normal mask) is non-zero. It is registered, so it follows a change of the raw vector or the mask one clock later. An external line change reaches it two clocks after the line is sampled.
- R2: `fiq_o` is high exactly when (raw level AND fast mask) is non-zero, with the same registered timing as R1.
- R3: Read index 0 returns raw AND normal mask. Index 1 returns the raw vector. Index 2 returns the normal mask.
- R4: Read index 8 returns raw AND fast mask. Index 9 returns the raw vector. Index 10 returns the fast mask.
- R5: A write to index 2 ORs the write data into the normal mask. A write to index 3 clears every mask bit that is 1 in the write data.
- R6: A write to index 10 ORs the write data into the fast mask. A write to index 11 clears every mask bit that is 1 in the write data.
- R7: A write to index 4 with data bit 0 set sets the software latch. A write to index 5 with data bit 0 set clears it. Other data bits are ignored. Read index 4 returns raw bit 0 in bit 0 and zeros elsewhere.
- R8: Raw bits 31..1 equal the request lines registered on the previous clock. Raw bit 0 is registered line 0 ORed with the software latch.
- R9: Reads of indices 3, 5, 11 and every unlisted index return 0. Writes to indices 0, 1, 8, 9 and every unlisted index change no state.
- R10: After reset, both masks and the software latch are 0, and both outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lines_i | input | 32 | Level-sensitive request lines |
| addr_i | input | 4 | Register word index |
| wr_en_i | input | 1 | Write strobe, acts on the rising clock edge |
| wr_data_i | input | 32 | Write data |
| rd_data_o | output | 32 | Read data for `addr_i`, combinational |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
The bench measures the two-clock latency from a line edge to `irq_o`. A design that dropped the input register or the output register would assert one clock early. Random writes that land on the status indices and the unlisted indices must leave both masks and the latch unchanged. An address decode that aliased a status index onto a set index would corrupt a mask there. A clear write that sets extra data bits exercises whether the latch reacts only to data bit 0. With line 0 held high while the latch is cleared, the bench checks that raw bit 0 still reads 1, which catches a latch that replaces line 0 rather than being ORed with it.

// File: rtl/dual_mask_intc.sv
module dual_mask_intc #(
  parameter int LINES  = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINES-1:0]  lines_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [LINES-1:0]  wr_data_i,
  output logic [LINES-1:0]  rd_data_o,
  output logic              irq_o,
  output logic              fiq_o
);
  localparam logic [ADDR_W-1:0] A_N_STAT = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_N_RAW  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_N_SET  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_N_CLR  = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_SW_SET = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_SW_CLR = ADDR_W'(5);
  localparam logic [ADDR_W-1:0] A_F_STAT = ADDR_W'(8);
  localparam logic [ADDR_W-1:0] A_F_RAW  = ADDR_W'(9);
  localparam logic [ADDR_W-1:0] A_F_SET  = ADDR_W'(10);
  localparam logic [ADDR_W-1:0] A_F_CLR  = ADDR_W'(11);

  logic [LINES-1:0] lines_q, n_mask, f_mask, raw;
  logic             sw_q;

  assign raw = {lines_q[LINES-1:1], lines_q[0] | sw_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lines_q <= '0;
      n_mask  <= '0;
      f_mask  <= '0;
      sw_q    <= 1'b0;
      irq_o   <= 1'b0;
      fiq_o   <= 1'b0;
    end else begin
      lines_q <= lines_i;
      irq_o   <= |(raw & n_mask);
      fiq_o   <= |(raw & f_mask);
      if (wr_en_i) begin
        case (addr_i)
          A_N_SET:  n_mask <= n_mask | wr_data_i;
          A_N_CLR:  n_mask <= n_mask & ~wr_data_i;
          A_F_SET:  f_mask <= f_mask | wr_data_i;
          A_F_CLR:  f_mask <= f_mask & ~wr_data_i;
          A_SW_SET: if (wr_data_i[0]) sw_q <= 1'b1;
          A_SW_CLR: if (wr_data_i[0]) sw_q <= 1'b0;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (addr_i)
      A_N_STAT: rd_data_o = raw & n_mask;
      A_N_RAW:  rd_data_o = raw;
      A_N_SET:  rd_data_o = n_mask;
      A_SW_SET: rd_data_o = {{(LINES-1){1'b0}}, raw[0]};
      A_F_STAT: rd_data_o = raw & f_mask;
      A_F_RAW:  rd_data_o = raw;
      A_F_SET:  rd_data_o = f_mask;
      default:  rd_data_o = '0;
    endcase
  end

  // R1
  n_masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(n_mask) == '0) |-> !irq_o);
  // R2
  f_masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(f_mask) == '0) |-> !fiq_o);
  // R5
  n_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && addr_i == A_N_SET) |=> ((n_mask & $past(wr_data_i)) == $past(wr_data_i)));
  // R6
  f_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && addr_i == A_F_CLR) |=> ((f_mask & $past(wr_data_i)) == '0));
  // R7
  sw_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && addr_i == A_SW_SET && wr_data_i[0]) |=> raw[0]);
  // R9
  stat_wr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && (addr_i == A_N_STAT || addr_i == A_F_RAW))
      |=> ($stable(n_mask) && $stable(f_mask) && $stable(sw_q)));
endmodule

// File: tb/dual_mask_intc_bench.sv
module dual_mask_intc_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] lines = '0;
  logic [3:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        irq, fiq;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  logic [31:0] m_n, m_f, m_lines;
  logic        m_sw;

  always #10 clk = ~clk;

  dual_mask_intc u_dual_mask_intc (
    .clk(clk), .rst_n(rst_n), .lines_i(lines), .addr_i(addr),
    .wr_en_i(wr_en), .wr_data_i(wr_data), .rd_data_o(rd_data),
    .irq_o(irq), .fiq_o(fiq));

  function automatic logic [31:0] exp_raw();
    return {m_lines[31:1], m_lines[0] | m_sw};
  endfunction

  function automatic logic [31:0] exp_read(input logic [3:0] idx);
    case (idx)
      4'd0:  return exp_raw() & m_n;
      4'd1:  return exp_raw();
      4'd2:  return m_n;
      4'd4:  return {31'b0, exp_raw() & 32'd1} ;
      4'd8:  return exp_raw() & m_f;
      4'd9:  return exp_raw();
      4'd10: return m_f;
      default: return '0;
    endcase
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] idx, input logic [31:0] d);
    @(negedge clk);
    addr = idx; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    case (idx)
      4'd2:  m_n = m_n | d;
      4'd3:  m_n = m_n & ~d;
      4'd10: m_f = m_f | d;
      4'd11: m_f = m_f & ~d;
      4'd4:  if (d[0]) m_sw = 1'b1;
      4'd5:  if (d[0]) m_sw = 1'b0;
      default: ;
    endcase
  endtask

  task automatic rd_chk(input logic [3:0] idx, input string req);
    @(negedge clk);
    addr = idx;
    #1;
    chk(rd_data, exp_read(idx), req);
  endtask

  task automatic settle_outs(input string req);
    repeat (2) @(negedge clk);
    chk({31'b0, irq}, {31'b0, |(exp_raw() & m_n)}, {req, " R1 irq"});
    chk({31'b0, fiq}, {31'b0, |(exp_raw() & m_f)}, {req, " R2 fiq"});
  endtask

  initial begin
    m_n = '0; m_f = '0; m_lines = '0; m_sw = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10 reset state
    @(negedge clk);
    chk({31'b0, irq}, 32'd0, "R10 irq");
    chk({31'b0, fiq}, 32'd0, "R10 fiq");
    rd_chk(4'd2, "R10 nmask");
    rd_chk(4'd10, "R10 fmask");
    rd_chk(4'd4, "R10 soft");

    // R1 latency: mask bit 5, raise line 5
    wr(4'd2, 32'h20);
    @(negedge clk);
    lines = 32'h20; m_lines = lines;
    @(negedge clk);
    chk({31'b0, irq}, 32'd0, "R1 latency early");
    @(negedge clk);
    chk({31'b0, irq}, 32'd1, "R1 latency");
    chk({31'b0, fiq}, 32'd0, "R2 unmasked");
    rd_chk(4'd0, "R3 nstat");
    rd_chk(4'd1, "R8 raw");
    rd_chk(4'd9, "R4 raw");

    // R6 fiq mask set/clear
    wr(4'd10, 32'h8000_0020);
    settle_outs("R6 set");
    rd_chk(4'd10, "R6 fmask");
    rd_chk(4'd8, "R4 fstat");
    wr(4'd11, 32'h0000_0020);
    settle_outs("R6 clr");
    rd_chk(4'd10, "R6 fmask clr");
    wr(4'd3, 32'hFFFF_FFFF);
    settle_outs("R5 clr");
    rd_chk(4'd2, "R5 nmask clr");

    // R7 software line 0, others bits ignored
    wr(4'd2, 32'h1);
    wr(4'd4, 32'hFFFF_FFFE);
    rd_chk(4'd4, "R7 bit0 only ignored");
    wr(4'd4, 32'h1);
    settle_outs("R7 soft set");
    rd_chk(4'd4, "R7 soft read");
    rd_chk(4'd1, "R8 raw with soft");
    @(negedge clk);
    lines = 32'h1; m_lines = lines;
    wr(4'd5, 32'hFFFF_FFFF);
    settle_outs("R8 line0 held");
    rd_chk(4'd4, "R8 line0 OR soft");
    @(negedge clk);
    lines = 32'h0; m_lines = lines;
    settle_outs("R7 soft clr");

    // R9 write-ignored and read-zero indices
    wr(4'd0, 32'hFFFF_FFFF);
    wr(4'd1, 32'hFFFF_FFFF);
    wr(4'd8, 32'hFFFF_FFFF);
    wr(4'd9, 32'hFFFF_FFFF);
    wr(4'd14, 32'hFFFF_FFFF);
    rd_chk(4'd2, "R9 nmask untouched");
    rd_chk(4'd10, "R9 fmask untouched");
    rd_chk(4'd4, "R9 soft untouched");
    rd_chk(4'd3, "R9 read clr idx");
    rd_chk(4'd5, "R9 read sw clr idx");
    rd_chk(4'd11, "R9 read fclr idx");

    // random mix
    void'($urandom(32'd20240611));
    for (int i = 0; i < 400; i++) begin
      int op;
      op = $urandom_range(0, 3);
      if (op == 0) begin
        @(negedge clk);
        lines = $urandom() & $urandom(); m_lines = lines;
      end else begin
        logic [3:0] idx;
        logic [31:0] d;
        idx = 4'($urandom_range(0, 15));
        d = $urandom();
        wr(idx, d);
      end
      settle_outs("R1 R2 random");
      rd_chk(4'($urandom_range(0, 15)), "R3 R4 R5 R6 R9 random read");
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule